// File: doc/BRIEF.md
# Pipelined Polynomial Expression Unit

This block evaluates the signed product X = (3A + 5B)(2C - D) on four signed operands of equal width. It takes one operand set per clock and returns one full-precision result per clock, after a fixed latency of two clock edges. A valid flag travels with each operand set, so a consumer can match results to their inputs without extra bookkeeping.

The expression is split into independent sub-operations that run side by side. The first register stage holds the four scaled terms: triple A, quintuple B, double C and the negation of D. The constant scalings are built from shifts and adds. The second register stage holds the two sums, with their widths grown so that no sum can overflow. A single multiplier combines the two registered sums. The longest path from register to output is therefore one multiply, not the whole chain of operations.

Top module: `poly_expr_unit`

## Requirements
- R1: While rst_ni is low, and after a reset asserted mid-stream, valid_o reads 0 and x_o reads 0. This holds until new valid input has had two clock edges to propagate.
- R2: valid_o is high exactly two rising clock edges after valid_i was sampled high. It is low two edges after valid_i was sampled low.
- R3: When valid_o is high, x_o as a two's complement value of width 2*DATA_W+7 equals (3a + 5b)(2c - d). Here a, b, c and d are the operands sampled two edges earlier, read as two's complement values.
- R4: Operand sets presented on consecutive cycles give results on consecutive cycles, one per clock, with no stall.
- R5: The extreme operand values (most negative and most positive) in every combination give the exact product with no wraparound. |x_o| never exceeds 3 * 2^(2*DATA_W+1).
- R6: Cycles with valid_i low insert bubbles. The surrounding valid results keep their order and values, and each bubble gives valid_o low at its own position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand set valid |
| a_i | input | DATA_W | Operand A, signed |
| b_i | input | DATA_W | Operand B, signed |
| c_i | input | DATA_W | Operand C, signed |
| d_i | input | DATA_W | Operand D, signed |
| valid_o | output | 1 | Result valid |
| x_o | output | 2*DATA_W+7 | Result X, signed, full precision |

## Verification
The bench builds the unit with DATA_W = 8. At that width the 23-bit result and every intermediate value fit well inside a 64-bit reference model in the bench. The 256 values per operand also let directed tests hit both extremes of every operand in every combination, alongside seeded random operand streams with random bubbles. A reset asserted mid-stream, while both stages are full, shows that every pipeline register clears.

// File: rtl/poly_pkg.sv
package poly_pkg;
  // headroom bits added over the operand width
  localparam int unsigned AB_GROW = 4;
  localparam int unsigned CD_GROW = 3;

  function automatic int unsigned result_width(int unsigned n);
    return (n + AB_GROW) + (n + CD_GROW);
  endfunction
endpackage

// File: rtl/poly_scale_stage.sv
module poly_scale_stage #(
  parameter int unsigned DATA_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic        [DATA_W-1:0] a_i,
  input  logic        [DATA_W-1:0] b_i,
  input  logic        [DATA_W-1:0] c_i,
  input  logic        [DATA_W-1:0] d_i,
  output logic                     valid_o,
  output logic signed [DATA_W+1:0] a3_o,
  output logic signed [DATA_W+2:0] b5_o,
  output logic signed [DATA_W:0]   c2_o,
  output logic signed [DATA_W:0]   dn_o
);
  localparam int unsigned A_W = DATA_W + 2;
  localparam int unsigned B_W = DATA_W + 3;
  localparam int unsigned C_W = DATA_W + 1;

  logic signed [A_W-1:0] a_ext, a3_d;
  logic signed [B_W-1:0] b_ext, b5_d;
  logic signed [C_W-1:0] c2_d, d_ext, dn_d;

  always_comb begin
    a_ext = {{2{a_i[DATA_W-1]}}, a_i};
    b_ext = {{3{b_i[DATA_W-1]}}, b_i};
    d_ext = {d_i[DATA_W-1], d_i};
    a3_d  = (a_ext <<< 1) + a_ext;
    b5_d  = (b_ext <<< 2) + b_ext;
    c2_d  = {c_i, 1'b0};
    dn_d  = -d_ext;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      a3_o    <= '0;
      b5_o    <= '0;
      c2_o    <= '0;
      dn_o    <= '0;
    end else begin
      valid_o <= valid_i;
      a3_o    <= a3_d;
      b5_o    <= b5_d;
      c2_o    <= c2_d;
      dn_o    <= dn_d;
    end
  end
endmodule

// File: rtl/poly_sum_stage.sv
module poly_sum_stage #(
  parameter int unsigned DATA_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [DATA_W+1:0] a3_i,
  input  logic signed [DATA_W+2:0] b5_i,
  input  logic signed [DATA_W:0]   c2_i,
  input  logic signed [DATA_W:0]   dn_i,
  output logic                     valid_o,
  output logic signed [DATA_W+3:0] ab_o,
  output logic signed [DATA_W+2:0] cd_o
);
  localparam int unsigned AB_W = DATA_W + poly_pkg::AB_GROW;
  localparam int unsigned CD_W = DATA_W + poly_pkg::CD_GROW;

  logic signed [AB_W-1:0] ab_d;
  logic signed [CD_W-1:0] cd_d;

  always_comb begin
    ab_d = {{2{a3_i[DATA_W+1]}}, a3_i} + {b5_i[DATA_W+2], b5_i};
    cd_d = {{2{c2_i[DATA_W]}}, c2_i} + {{2{dn_i[DATA_W]}}, dn_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      ab_o    <= '0;
      cd_o    <= '0;
    end else begin
      valid_o <= valid_i;
      ab_o    <= ab_d;
      cd_o    <= cd_d;
    end
  end
endmodule

// File: rtl/poly_mul_stage.sv
module poly_mul_stage #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned X_W = poly_pkg::result_width(DATA_W)
) (
  input  logic signed [DATA_W+3:0] ab_i,
  input  logic signed [DATA_W+2:0] cd_i,
  output logic signed [X_W-1:0]    x_o
);
  localparam int unsigned AB_W = DATA_W + poly_pkg::AB_GROW;
  localparam int unsigned CD_W = DATA_W + poly_pkg::CD_GROW;

  logic signed [X_W-1:0] ab_x, cd_x;

  always_comb begin
    ab_x = {{(X_W-AB_W){ab_i[AB_W-1]}}, ab_i};
    cd_x = {{(X_W-CD_W){cd_i[CD_W-1]}}, cd_i};
    x_o  = ab_x * cd_x;
  end
endmodule

// File: rtl/poly_expr_unit.sv
module poly_expr_unit #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned X_W = poly_pkg::result_width(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] c_i,
  input  logic [DATA_W-1:0] d_i,
  output logic              valid_o,
  output logic [X_W-1:0]    x_o
);
  logic                     s1_valid, s2_valid;
  logic signed [DATA_W+1:0] s1_a3;
  logic signed [DATA_W+2:0] s1_b5;
  logic signed [DATA_W:0]   s1_c2, s1_dn;
  logic signed [DATA_W+3:0] s2_ab;
  logic signed [DATA_W+2:0] s2_cd;
  logic signed [X_W-1:0]    prod;

  poly_scale_stage #(.DATA_W(DATA_W)) u_scale (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
    .a_i(a_i), .b_i(b_i), .c_i(c_i), .d_i(d_i),
    .valid_o(s1_valid), .a3_o(s1_a3), .b5_o(s1_b5), .c2_o(s1_c2), .dn_o(s1_dn)
  );

  poly_sum_stage #(.DATA_W(DATA_W)) u_sum (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(s1_valid),
    .a3_i(s1_a3), .b5_i(s1_b5), .c2_i(s1_c2), .dn_i(s1_dn),
    .valid_o(s2_valid), .ab_o(s2_ab), .cd_o(s2_cd)
  );

  // multiply sits alone between the last register and the output
  poly_mul_stage #(.DATA_W(DATA_W)) u_mul (
    .ab_i(s2_ab), .cd_i(s2_cd), .x_o(prod)
  );

  assign valid_o = s2_valid;
  assign x_o     = prod;
endmodule

// File: rtl/poly_expr_chk.sv
module poly_expr_chk #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned X_W = poly_pkg::result_width(DATA_W)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic [DATA_W-1:0] c_i,
  input logic [DATA_W-1:0] d_i,
  input logic              valid_o,
  input logic [X_W-1:0]    x_o
);
  logic [1:0]              age;
  logic [1:0]              v_dly;
  logic [4*DATA_W-1:0]     op_dly0, op_dly1;
  logic signed [X_W:0]     ref_x, bound, x_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      age     <= '0;
      v_dly   <= '0;
      op_dly0 <= '0;
      op_dly1 <= '0;
    end else begin
      if (age != 2'd2) age <= age + 2'd1;
      v_dly   <= {v_dly[0], valid_i};
      op_dly0 <= {a_i, b_i, c_i, d_i};
      op_dly1 <= op_dly0;
    end
  end

  always_comb begin
    ref_x = (3 * (X_W+1)'($signed(op_dly1[4*DATA_W-1 -: DATA_W]))
           + 5 * (X_W+1)'($signed(op_dly1[3*DATA_W-1 -: DATA_W])))
          * (2 * (X_W+1)'($signed(op_dly1[2*DATA_W-1 -: DATA_W]))
           - (X_W+1)'($signed(op_dly1[DATA_W-1:0])));
    bound = (X_W+1)'(3) <<< (2*DATA_W+1);
    x_s   = {x_o[X_W-1], x_o};
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age != 2'd2) |-> (!valid_o && x_o == '0));

  // R2
  valid_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age == 2'd2) |-> (valid_o == v_dly[1]));

  // R3
  result_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age == 2'd2 && valid_o) |-> (x_s == ref_x));

  // R5
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (x_s <= bound && x_s >= -bound));
endmodule

bind poly_expr_unit poly_expr_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
  .a_i(a_i), .b_i(b_i), .c_i(c_i), .d_i(d_i),
  .valid_o(valid_o), .x_o(x_o)
);

// File: tb/poly_expr_unit_tb.sv
module poly_expr_unit_tb;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned X_W = 2*DATA_W + 7;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              valid_i = 1'b0;
  logic [DATA_W-1:0] a_i = '0, b_i = '0, c_i = '0, d_i = '0;
  logic              valid_o;
  logic [X_W-1:0]    x_o;

  int checks = 0;
  int failures = 0;
  bit hv [0:1];
  longint hx [0:1];
  string htag [0:1];

  always #5 clk = ~clk;

  poly_expr_unit #(.DATA_W(DATA_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i),
    .a_i(a_i), .b_i(b_i), .c_i(c_i), .d_i(d_i),
    .valid_o(valid_o), .x_o(x_o)
  );

  function automatic longint sx(logic [DATA_W-1:0] v);
    return longint'($signed(v));
  endfunction

  function automatic longint ref_x(logic [DATA_W-1:0] a, b, c, d);
    return (3*sx(a) + 5*sx(b)) * (2*sx(c) - sx(d));
  endfunction

  function automatic longint sxo(logic [X_W-1:0] v);
    return longint'($signed(v));
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_hist();
    for (int i = 0; i < 2; i++) begin hv[i] = 1'b0; hx[i] = 0; htag[i] = "R1"; end
  endtask

  // one cycle: check output of the set driven two cycles ago, then drive a new set
  task automatic step(bit v, logic [DATA_W-1:0] a, b, c, d, string tag);
    @(negedge clk);
    check(valid_o == hv[1], (htag[1] == "R1") ? "R1" : "R2", longint'(valid_o), longint'(hv[1]));
    if (hv[1]) check(sxo(x_o) == hx[1], htag[1], sxo(x_o), hx[1]);
    hv[1] = hv[0]; hx[1] = hx[0]; htag[1] = htag[0];
    hv[0] = v; hx[0] = ref_x(a, b, c, d); htag[0] = tag;
    valid_i = v; a_i = a; b_i = b; c_i = c; d_i = d;
  endtask

  initial begin
    #1500000;
    failures++;
    checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [DATA_W-1:0] ext [0:1];
    void'($urandom(32'd1234));
    clear_hist();
    ext[0] = {1'b1, {(DATA_W-1){1'b0}}};
    ext[1] = {1'b0, {(DATA_W-1){1'b1}}};

    // R1: reset state
    repeat (3) @(negedge clk);
    check(valid_o == 1'b0, "R1", longint'(valid_o), 0);
    check(x_o == '0, "R1", sxo(x_o), 0);
    rst_ni = 1'b1;

    // R3: directed small values
    step(1'b1, 8'd1, 8'd1, 8'd1, 8'd1, "R3");
    step(1'b1, 8'd0, 8'd0, 8'd5, 8'd3, "R3");
    step(1'b1, 8'hFF, 8'd2, 8'hFE, 8'd7, "R3");

    // R5: all extreme combinations back to back
    for (int k = 0; k < 16; k++)
      step(1'b1, ext[k[0]], ext[k[1]], ext[k[2]], ext[k[3]], "R5");

    // R2: isolated single valid pulses
    for (int k = 0; k < 3; k++) begin
      step(1'b1, 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), "R2");
      step(1'b0, 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), "R2");
      step(1'b0, 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), "R2");
    end

    // R4: long fully-valid burst
    for (int k = 0; k < 300; k++)
      step(1'b1, 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), "R4");

    // R6: random bubbles
    for (int k = 0; k < 300; k++)
      step(1'(($urandom % 3) != 0), 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), "R6");

    // R1: reset mid-stream with both stages full
    step(1'b1, 8'd9, 8'd9, 8'd9, 8'd9, "R3");
    step(1'b1, 8'd7, 8'd7, 8'd7, 8'd7, "R3");
    #2;
    rst_ni = 1'b0;
    valid_i = 1'b0;
    #1;
    check(valid_o == 1'b0, "R1", longint'(valid_o), 0);
    check(x_o == '0, "R1", sxo(x_o), 0);
    clear_hist();
    @(negedge clk);
    rst_ni = 1'b1;
    step(1'b0, '0, '0, '0, '0, "R1");
    step(1'b1, 8'd3, 8'hFD, 8'd4, 8'hF0, "R3");
    step(1'b0, '0, '0, '0, '0, "R2");
    step(1'b0, '0, '0, '0, '0, "R2");
    step(1'b0, '0, '0, '0, '0, "R2");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule